// File: doc/BRIEF.md
# Shared Floating-Point / Packed-Integer Register File

This block is a small register file used by two execution units. A floating-point unit and a packed-integer unit both access it, and they use the same storage. There are eight entries of 80 bits. Each packed register is the low 64 bits of the floating-point entry with the same index. Every entry has a tag that marks it empty or full. The tags tell the floating-point side which entries hold live values.

The file is always in one of two modes. While it is in floating-point mode, the floating-point ports work normally. The first packed access moves the file into packed mode and marks every tag full. A packed write stores its 64-bit operand in the mantissa bits and forces the sign-and-exponent field to a fixed pattern. The pattern is a cleared sign with all-ones exponent bits, so a floating-point reader would see a non-number.

Floating-point access while in packed mode is illegal. So is floating-point and packed access in the same cycle. Such a cycle is refused and reported on the error output. The way back to floating-point mode is an empty command. It empties every tag at once and then raises busy for a fixed stall of 53 cycles. During that stall the block refuses all traffic. When the stall ends, the file is in floating-point mode.

Top module: `alias_regfile`

## Requirements
- R1: After reset the file is in floating-point mode (pk_mode low), busy and err are low, every tag is empty, and every entry reads as zero.
- R2: In floating-point mode, a floating-point write stores all 80 bits and marks that one entry full. A floating-point read returns all 80 bits in the same cycle. A read port whose enable is low returns zero.
- R3: A packed write stores its operand in bits 63..0 of the entry, sets bit 79 to 0, and sets bits 78..64 to all ones.
- R4: A packed read returns bits 63..0 of the entry with the same index, including a value written earlier through the floating-point port.
- R5: A packed access accepted in floating-point mode raises pk_mode at the next edge and marks all eight tags full.
- R6: A floating-point read or write while pk_mode is high is refused. The read returns zero, the write changes nothing, and err is high for exactly the one following cycle.
- R7: Floating-point and packed access in the same cycle is refused as a whole. Nothing is stored, a packed read returns zero, the mode does not change, and err is high in the next cycle.
- R8: An empty command accepted while busy is low empties every tag at the next edge. From that edge, busy stays high for exactly 53 cycles.
- R9: While busy is high, every read, write and empty command is ignored. Reads return zero, nothing is stored, err stays low, and the stall is not extended.
- R10: When busy falls, the file is in floating-point mode with all tags empty, and floating-point accesses are accepted again.
- R11: An empty command takes priority over accesses in the same cycle. Those accesses are dropped without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_wr_en | input | 1 | Floating-point write request |
| fp_wr_idx | input | 3 | Floating-point write entry index |
| fp_wr_data | input | 80 | Floating-point write value |
| fp_rd_en | input | 1 | Floating-point read request |
| fp_rd_idx | input | 3 | Floating-point read index; also selects the tag shown on fp_rd_full |
| fp_rd_data | output | 80 | Floating-point read value, zero when refused or not enabled |
| fp_rd_full | output | 1 | Tag of entry fp_rd_idx (1 = full) |
| pk_wr_en | input | 1 | Packed write request |
| pk_wr_idx | input | 3 | Packed write register index |
| pk_wr_data | input | 64 | Packed write value |
| pk_rd_en | input | 1 | Packed read request |
| pk_rd_idx | input | 3 | Packed read register index |
| pk_rd_data | output | 64 | Packed read value, zero when refused or not enabled |
| empty_cmd | input | 1 | Empty-state command: clear all tags, start the stall |
| busy | output | 1 | High during the fixed stall |
| err | output | 1 | One-cycle flag for an illegal mixed access |
| pk_mode | output | 1 | High while the file is in packed mode |

## Verification
The main function is driven with a table of floating-point writes to scattered entries. Each value has a different sign-and-exponent field, and reading them back shows that all 80 bits are kept and only the addressed tag changes. Packed reads of those entries separate real aliasing from separate storage. A floating-point read issued after a packed write and an empty command shows the forced exponent pattern.

Error cases are checked in isolation, one each:
- a lone floating-point read in packed mode;
- a lone floating-point write in packed mode;
- a floating-point access and a packed access in the same cycle.

The stall is probed in every cycle with a mix of traffic and a repeated empty command. This separates a stall that swallows traffic from one that only delays it or can be restarted.

// File: rtl/arf_pkg.sv
`timescale 1ns/1ps
package arf_pkg;

   typedef enum logic {
      ARF_FP = 1'b0,
      ARF_PK = 1'b1
   } arf_mode_e;

endpackage

// File: rtl/arf_ctrl.sv
`timescale 1ns/1ps
module arf_ctrl
   import arf_pkg::*;
#(
   parameter int unsigned STALL_CYCLES = 53
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fp_acc,
   input  logic pk_acc,
   input  logic empty_cmd,
   output logic busy,
   output logic err,
   output logic pk_mode,
   output logic fp_ok,
   output logic pk_ok,
   output logic clr_tags,
   output logic set_tags
);

   localparam int unsigned CW = $clog2(STALL_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(STALL_CYCLES);
   localparam logic [CW-1:0] LAST_VAL = CW'(1);

   logic [CW-1:0] cnt_q;
   arf_mode_e     mode_q;
   logic          open_c;
   logic          clash_c;

   always_comb begin
      busy     = (cnt_q != '0);
      open_c   = !busy && !empty_cmd;
      fp_ok    = open_c && fp_acc && !pk_acc && (mode_q == ARF_FP);
      pk_ok    = open_c && pk_acc && !fp_acc;
      clash_c  = open_c && fp_acc && (pk_acc || (mode_q == ARF_PK));
      clr_tags = !busy && empty_cmd;
      set_tags = pk_ok;
      pk_mode  = (mode_q == ARF_PK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= ARF_FP;
         err    <= 1'b0;
      end else begin
         err <= clash_c;
         if (clr_tags) begin
            cnt_q <= LOAD_VAL;
         end else if (busy) begin
            cnt_q <= cnt_q - LAST_VAL;
         end
         if (busy && (cnt_q == LAST_VAL)) begin
            mode_q <= ARF_FP;
         end else if (pk_ok) begin
            mode_q <= ARF_PK;
         end
      end
   end

endmodule

// File: rtl/arf_store.sv
`timescale 1ns/1ps
module arf_store #(
   parameter int unsigned N   = 8,
   parameter int unsigned FPW = 80,
   parameter int unsigned PKW = 64,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fp_we,
   input  logic [IW-1:0]  fp_widx,
   input  logic [FPW-1:0] fp_wdata,
   input  logic           pk_we,
   input  logic [IW-1:0]  pk_widx,
   input  logic [PKW-1:0] pk_wdata,
   input  logic           clr_tags,
   input  logic           set_tags,
   output logic [FPW-1:0] ent_q [N],
   output logic [N-1:0]   tag_q
);

   localparam int unsigned EXPW = FPW - PKW;

   logic [FPW-1:0] pk_image;

   always_comb begin
      pk_image = {1'b0, {(EXPW - 1){1'b1}}, pk_wdata};
   end

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic fp_hit;
      logic pk_hit;

      always_comb begin
         fp_hit = fp_we && (fp_widx == IW'(g));
         pk_hit = pk_we && (pk_widx == IW'(g));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q[g] <= '0;
            tag_q[g] <= 1'b0;
         end else begin
            if (fp_hit) begin
               ent_q[g] <= fp_wdata;
            end else if (pk_hit) begin
               ent_q[g] <= pk_image;
            end
            if (clr_tags) begin
               tag_q[g] <= 1'b0;
            end else if (set_tags || fp_hit) begin
               tag_q[g] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/alias_regfile.sv
`timescale 1ns/1ps
module alias_regfile #(
   parameter int unsigned NUM_ENTRIES  = 8,
   parameter int unsigned FP_WIDTH     = 80,
   parameter int unsigned PK_WIDTH     = 64,
   parameter int unsigned STALL_CYCLES = 53,
   parameter int unsigned READ_REG     = 0,
   localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fp_wr_en,
   input  logic [IDX_W-1:0]    fp_wr_idx,
   input  logic [FP_WIDTH-1:0] fp_wr_data,
   input  logic                fp_rd_en,
   input  logic [IDX_W-1:0]    fp_rd_idx,
   output logic [FP_WIDTH-1:0] fp_rd_data,
   output logic                fp_rd_full,
   input  logic                pk_wr_en,
   input  logic [IDX_W-1:0]    pk_wr_idx,
   input  logic [PK_WIDTH-1:0] pk_wr_data,
   input  logic                pk_rd_en,
   input  logic [IDX_W-1:0]    pk_rd_idx,
   output logic [PK_WIDTH-1:0] pk_rd_data,
   input  logic                empty_cmd,
   output logic                busy,
   output logic                err,
   output logic                pk_mode
);

   if (NUM_ENTRIES < 2 || (1 << IDX_W) != NUM_ENTRIES) begin : g_bad_depth
      $error("alias_regfile: NUM_ENTRIES must be a power of two, at least 2");
   end
   if (PK_WIDTH + 2 > FP_WIDTH) begin : g_bad_width
      $error("alias_regfile: FP_WIDTH must exceed PK_WIDTH by at least 2");
   end
   if (STALL_CYCLES < 1) begin : g_bad_stall
      $error("alias_regfile: STALL_CYCLES must be at least 1");
   end
   if (READ_REG > 1) begin : g_bad_rdmode
      $error("alias_regfile: READ_REG must be 0 or 1");
   end

   logic                fp_acc;
   logic                pk_acc;
   logic                fp_ok;
   logic                pk_ok;
   logic                clr_tags;
   logic                set_tags;
   logic                fp_rd_go;
   logic                pk_rd_go;
   logic [FP_WIDTH-1:0] ent_q [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] tag_q;
   logic [FP_WIDTH-1:0] fp_sel;
   logic [PK_WIDTH-1:0] pk_sel;

   always_comb begin
      fp_acc   = fp_wr_en || fp_rd_en;
      pk_acc   = pk_wr_en || pk_rd_en;
      fp_rd_go = fp_ok && fp_rd_en;
      pk_rd_go = pk_ok && pk_rd_en;
      fp_sel   = ent_q[fp_rd_idx];
      pk_sel   = ent_q[pk_rd_idx][PK_WIDTH-1:0];
   end

   arf_ctrl #(
      .STALL_CYCLES (STALL_CYCLES)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fp_acc    (fp_acc),
      .pk_acc    (pk_acc),
      .empty_cmd (empty_cmd),
      .busy      (busy),
      .err       (err),
      .pk_mode   (pk_mode),
      .fp_ok     (fp_ok),
      .pk_ok     (pk_ok),
      .clr_tags  (clr_tags),
      .set_tags  (set_tags)
   );

   arf_store #(
      .N   (NUM_ENTRIES),
      .FPW (FP_WIDTH),
      .PKW (PK_WIDTH)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fp_we    (fp_ok && fp_wr_en),
      .fp_widx  (fp_wr_idx),
      .fp_wdata (fp_wr_data),
      .pk_we    (pk_ok && pk_wr_en),
      .pk_widx  (pk_wr_idx),
      .pk_wdata (pk_wr_data),
      .clr_tags (clr_tags),
      .set_tags (set_tags),
      .ent_q    (ent_q),
      .tag_q    (tag_q)
   );

   if (READ_REG == 0) begin : g_rd_comb
      always_comb begin
         fp_rd_data = fp_rd_go ? fp_sel : '0;
         pk_rd_data = pk_rd_go ? pk_sel : '0;
         fp_rd_full = tag_q[fp_rd_idx];
      end
   end else begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fp_rd_data <= '0;
            pk_rd_data <= '0;
            fp_rd_full <= 1'b0;
         end else begin
            fp_rd_data <= fp_rd_go ? fp_sel : '0;
            pk_rd_data <= pk_rd_go ? pk_sel : '0;
            fp_rd_full <= tag_q[fp_rd_idx];
         end
      end
   end

endmodule

// File: rtl/arf_checker.sv
`timescale 1ns/1ps
module arf_checker #(
   parameter int unsigned STALL_CYCLES = 53,
   parameter int unsigned READ_REG     = 0,
   parameter int unsigned FPW          = 80,
   parameter int unsigned PKW          = 64
) (
   input logic           clk,
   input logic           rst_n,
   input logic           fp_wr_en,
   input logic           fp_rd_en,
   input logic [FPW-1:0] fp_rd_data,
   input logic           fp_rd_full,
   input logic           pk_wr_en,
   input logic           pk_rd_en,
   input logic [PKW-1:0] pk_rd_data,
   input logic           empty_cmd,
   input logic           busy,
   input logic           err,
   input logic           pk_mode
);

   localparam int unsigned RW = $clog2(STALL_CYCLES + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (busy) begin
         run_q <= run_q + RW'(1);
      end else begin
         run_q <= '0;
      end
   end

   AST_EMPTY_STARTS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(empty_cmd)); // R8
   AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RW'(STALL_CYCLES))); // R8
   AST_STALL_ENDS_FP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !pk_mode); // R10
   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !err); // R9
   AST_ERR_NEEDS_FP: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(fp_rd_en || fp_wr_en)); // R6
   AST_PK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pk_mode) |-> $past(pk_rd_en || pk_wr_en)); // R5

   if (READ_REG == 0) begin : g_comb_checks
      AST_PK_TAGS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         (pk_mode && !busy) |-> fp_rd_full); // R5
      AST_FP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
         ((pk_mode || busy) && fp_rd_en) |-> (fp_rd_data == '0)); // R6
      AST_PK_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && pk_rd_en) |-> (pk_rd_data == '0)); // R9
   end

endmodule

bind alias_regfile arf_checker #(
   .STALL_CYCLES (STALL_CYCLES),
   .READ_REG     (READ_REG),
   .FPW          (FP_WIDTH),
   .PKW          (PK_WIDTH)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .fp_wr_en   (fp_wr_en),
   .fp_rd_en   (fp_rd_en),
   .fp_rd_data (fp_rd_data),
   .fp_rd_full (fp_rd_full),
   .pk_wr_en   (pk_wr_en),
   .pk_rd_en   (pk_rd_en),
   .pk_rd_data (pk_rd_data),
   .empty_cmd  (empty_cmd),
   .busy       (busy),
   .err        (err),
   .pk_mode    (pk_mode)
);

// File: tb/alias_regfile_tb_top.sv
`timescale 1ns/1ps
module alias_regfile_tb_top;

   localparam int STALL = 53;

   // table: {index, 80-bit value} written through the FP port then read back
   localparam logic [82:0] VECS [4] = '{
      {3'd0, 80'h3FFF_8000_0000_0000_0001},
      {3'd3, 80'hC005_A5A5_5A5A_F00D_BEEF},
      {3'd5, 80'h4000_FFFF_0000_FFFF_0000},
      {3'd6, 80'h7FFE_1234_5678_9ABC_DEF0}
   };

   localparam logic [63:0] PKV = 64'h0123_4567_89AB_CDEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fp_wr_en, fp_rd_en, pk_wr_en, pk_rd_en, empty_cmd;
   logic [2:0]  fp_wr_idx, fp_rd_idx, pk_wr_idx, pk_rd_idx;
   logic [79:0] fp_wr_data;
   logic [63:0] pk_wr_data;
   logic [79:0] fp_rd_data;
   logic [63:0] pk_rd_data;
   logic        fp_rd_full, busy, err, pk_mode;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   alias_regfile dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fp_wr_en   (fp_wr_en),
      .fp_wr_idx  (fp_wr_idx),
      .fp_wr_data (fp_wr_data),
      .fp_rd_en   (fp_rd_en),
      .fp_rd_idx  (fp_rd_idx),
      .fp_rd_data (fp_rd_data),
      .fp_rd_full (fp_rd_full),
      .pk_wr_en   (pk_wr_en),
      .pk_wr_idx  (pk_wr_idx),
      .pk_wr_data (pk_wr_data),
      .pk_rd_en   (pk_rd_en),
      .pk_rd_idx  (pk_rd_idx),
      .pk_rd_data (pk_rd_data),
      .empty_cmd  (empty_cmd),
      .busy       (busy),
      .err        (err),
      .pk_mode    (pk_mode)
   );

   task automatic chk(input string rq, input logic [79:0] act, input logic [79:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic idle();
      fp_wr_en = 0; fp_rd_en = 0; pk_wr_en = 0; pk_rd_en = 0; empty_cmd = 0;
      fp_wr_idx = 0; fp_rd_idx = 0; pk_wr_idx = 0; pk_rd_idx = 0;
      fp_wr_data = '0; pk_wr_data = '0;
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      int rd_bad;
      int saw_err;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 busy", 80'(busy), 80'd0);
      chk("R1 err", 80'(err), 80'd0);
      chk("R1 pk_mode", 80'(pk_mode), 80'd0);
      for (int i = 0; i < 8; i++) begin
         fp_rd_idx = 3'(i);
         #0.1;
         chk("R1 tag empty", 80'(fp_rd_full), 80'd0);
      end
      fp_rd_en = 1; fp_rd_idx = 0;
      #1;
      chk("R1 entry zero", fp_rd_data, 80'd0);

      // R2 table walk: write then read back through FP port
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); idle();
         fp_wr_en = 1; fp_wr_idx = VECS[i][82:80]; fp_wr_data = VECS[i][79:0];
         @(negedge clk); idle();
         fp_rd_en = 1; fp_rd_idx = VECS[i][82:80];
         #1;
         chk("R2 fp readback", fp_rd_data, VECS[i][79:0]);
         chk("R2 tag set", 80'(fp_rd_full), 80'd1);
      end
      fp_rd_en = 0; fp_rd_idx = 7;
      #0.1;
      chk("R2 untouched tag", 80'(fp_rd_full), 80'd0);
      chk("R2 disabled read zero", fp_rd_data, 80'd0);

      // R4 packed read of an FP-written entry, switches mode (R5)
      @(negedge clk); idle();
      pk_rd_en = 1; pk_rd_idx = 3;
      #1;
      chk("R4 alias low bits", 80'(pk_rd_data), 80'(VECS[1][63:0]));
      @(negedge clk); idle();
      chk("R5 mode packed", 80'(pk_mode), 80'd1);
      fp_rd_idx = 7;
      #0.1;
      chk("R5 all tags full", 80'(fp_rd_full), 80'd1);

      // R3 packed write, read back
      @(negedge clk); idle();
      pk_wr_en = 1; pk_wr_idx = 2; pk_wr_data = PKV;
      @(negedge clk); idle();
      pk_rd_en = 1; pk_rd_idx = 2;
      #1;
      chk("R3 packed readback", 80'(pk_rd_data), 80'(PKV));

      // R6 FP read in packed mode
      @(negedge clk); idle();
      fp_rd_en = 1; fp_rd_idx = 2;
      #1;
      chk("R6 fp read refused", fp_rd_data, 80'd0);
      @(negedge clk); idle();
      chk("R6 err pulse", 80'(err), 80'd1);
      @(negedge clk);
      chk("R6 err one cycle", 80'(err), 80'd0);
      fp_wr_en = 1; fp_wr_idx = 2; fp_wr_data = 80'hFFFF_FFFF_FFFF_FFFF_FFFF;
      @(negedge clk); idle();
      chk("R6 err on write", 80'(err), 80'd1);
      pk_rd_en = 1; pk_rd_idx = 2;
      #1;
      chk("R6 write ignored", 80'(pk_rd_data), 80'(PKV));

      // R8 empty command and stall, R9 traffic ignored
      @(negedge clk); idle();
      empty_cmd = 1;
      @(negedge clk); idle();
      chk("R8 busy starts", 80'(busy), 80'd1);
      fp_rd_idx = 7;
      #0.1;
      chk("R8 tags cleared", 80'(fp_rd_full), 80'd0);
      n = 1; rd_bad = 0; saw_err = 0;
      forever begin
         @(negedge clk); idle();
         if (!busy) break;
         n++;
         pk_wr_en = 1; pk_wr_idx = 2; pk_wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
         fp_rd_en = 1; fp_rd_idx = 2;
         pk_rd_en = (n % 2 == 0); pk_rd_idx = 2;
         empty_cmd = (n == 10);
         #1;
         if (fp_rd_data != 0 || pk_rd_data != 0) rd_bad++;
         if (err) saw_err++;
      end
      chk("R8 stall length", 80'(n), 80'(STALL));
      chk("R9 reads zero while busy", 80'(rd_bad), 80'd0);
      chk("R9 no err while busy", 80'(saw_err), 80'd0);
      chk("R9 no err after", 80'(err), 80'd0);

      // R10 back in FP mode, tags empty; R3 exponent fill visible
      chk("R10 fp mode", 80'(pk_mode), 80'd0);
      fp_rd_en = 1; fp_rd_idx = 2;
      #1;
      chk("R3 exponent filled", fp_rd_data, {1'b0, 15'h7FFF, PKV});
      chk("R10 tag empty", 80'(fp_rd_full), 80'd0);
      @(negedge clk); idle();
      fp_wr_en = 1; fp_wr_idx = 4; fp_wr_data = 80'h1234_0000_1111_2222_3333;
      @(negedge clk); idle();
      fp_rd_en = 1; fp_rd_idx = 4;
      #1;
      chk("R10 fp write accepted", fp_rd_data, 80'h1234_0000_1111_2222_3333);
      chk("R10 tag full", 80'(fp_rd_full), 80'd1);

      // R7 simultaneous FP and packed access
      @(negedge clk); idle();
      fp_wr_en = 1; fp_wr_idx = 5; fp_wr_data = 80'hAAAA_AAAA_AAAA_AAAA_AAAA;
      pk_rd_en = 1; pk_rd_idx = 5;
      #1;
      chk("R7 packed read refused", 80'(pk_rd_data), 80'd0);
      @(negedge clk); idle();
      chk("R7 err", 80'(err), 80'd1);
      chk("R7 mode unchanged", 80'(pk_mode), 80'd0);
      fp_rd_en = 1; fp_rd_idx = 5;
      #1;
      chk("R7 nothing stored", fp_rd_data, VECS[2][79:0]);
      chk("R7 tag unchanged", 80'(fp_rd_full), 80'd0);

      // R11 empty command wins over same-cycle access
      @(negedge clk); idle();
      empty_cmd = 1; pk_wr_en = 1; pk_wr_idx = 1; pk_wr_data = 64'h5555_5555_5555_5555;
      @(negedge clk); idle();
      chk("R11 busy", 80'(busy), 80'd1);
      chk("R11 mode not packed", 80'(pk_mode), 80'd0);
      chk("R11 no err", 80'(err), 80'd0);
      while (busy) @(negedge clk);
      fp_rd_en = 1; fp_rd_idx = 1;
      #1;
      chk("R11 write dropped", fp_rd_data, 80'd0);

      @(negedge clk); idle();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule